// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects a parameterised set of interrupt source lines (96 by default, grouped in three banks of 32) and presents them to a processor through one interrupt output and a small word-addressed register bus. Each bank has a pending view, an enable register and a mask register. A source is active when it is pending, enabled and not masked. The interrupt output is the registered OR of every active source. A vector register reports the lowest-numbered active source, scaled by four.

Source 0 is special. It is an external non-maskable-style input whose trigger type is chosen in a control register, and its pending bit is held until software clears it. All other sources are level-driven, so their pending bits follow the input lines and need no acknowledge. The vector register reads zero both when nothing is active and when source 0 is the active source. Software tells the two cases apart by reading bit 0 of pending bank 0.

A build-time parameter moves the enable and mask register groups from their standard base to an alternate, lower base.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, every enable, mask, protection and trigger-control register reads zero, the vector register reads zero and `irq_o` is low.
- R2: A read of the vector register (offset 0x00) returns the index of the lowest-numbered active source in bits [8:2], with all other bits zero. It returns zero when no source is active.
- R3: A pending source whose enable bit is 0 has no effect on `irq_o` or on the vector register.
- R4: A source whose mask bit is 1 is blocked from `irq_o` and from the vector register, even when its enable bit is 1.
- R5: `irq_o` equals the OR of all active sources as sampled at the previous rising clock edge. It changes one clock after a source, enable or mask change.
- R6: For sources 1 to 95, a pending read returns the live input level, whatever the enable and mask bits are. Writing ones to those pending bits has no effect.
- R7: With trigger control 0, a high level on source 0 sets pending bit 0 of bank 0 (offset 0x10). The bit stays set after the line falls, until a write with bit 0 = 1 to offset 0x10. A write with bit 0 = 0 leaves it set, and a trigger in the same cycle as the clear wins.
- R8: The trigger-control register at offset 0x0C holds bits [1:0] and reads zero elsewhere. The codes are 0 = high level, 1 = low level, 2 = rising edge, 3 = falling edge, and they decide what sets pending bit 0.
- R9: The protection register at offset 0x08 stores bit 0 only. Its other bits read zero.
- R10: Pending banks are at 0x10, 0x14 and 0x18. With `ALT_MAP=0`, enable and mask banks are at 0x40+4·bank and 0x50+4·bank. With `ALT_MAP=1`, they are at 0x20+4·bank and 0x30+4·bank. Any other offset reads zero and ignores writes.
- R11: When several sources are active, the vector register reports the lowest-numbered one, and it changes to the next one as soon as that source goes inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 96 | Interrupt source lines; bit 0 is the external triggered input |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Byte offset of the register accessed |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The bench checks the ambiguous zero on the vector register. It distinguishes an active source 0 from an idle controller through the pending bit, so a design that folded the two cases together, or that reported the highest index instead of the lowest, would give the wrong vector. It also tests the set-wins-over-clear rule and each of the four trigger codes on source 0, where a design that treated edges as levels would re-latch after a clear. It checks the mask-over-enable rule, the one-cycle lag of the interrupt output, and the alternate register base with its now-unmapped standard offsets, where a decode error shows up as a value read back from the wrong place.

// File: rtl/intc_pkg.sv
// Shared constants and types of the vectored interrupt controller.
// Assumes byte offsets on a word-aligned register bus.
package intc_pkg;

    localparam int OFF_VECTOR   = 32'h00;
    localparam int OFF_PROTECT  = 32'h08;
    localparam int OFF_TRIGCTL  = 32'h0C;
    localparam int OFF_PENDING  = 32'h10;
    localparam int EN_BASE_STD  = 32'h40;
    localparam int MSK_BASE_STD = 32'h50;
    localparam int EN_BASE_ALT  = 32'h20;
    localparam int MSK_BASE_ALT = 32'h30;

    // Trigger type for source 0; the encoding is visible at offset 0x0C.
    typedef enum logic [1:0] {
        TRIG_HIGH = 2'd0,
        TRIG_LOW  = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_FALL = 2'd3
    } trig_e;

endpackage

// File: rtl/intc_bank.sv
// One bank of enable and mask state for BANK_W sources.
// Produces the active vector pending & enable & ~mask.
// Assumes the write strobes are decoded one-hot by the parent.
module intc_bank #(
    parameter int BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we_i,
    input  logic              msk_we_i,
    input  logic [31:0]       wdata_i,
    input  logic [BANK_W-1:0] pend_i,
    output logic [BANK_W-1:0] en_o,
    output logic [BANK_W-1:0] msk_o,
    output logic [BANK_W-1:0] act_o
);

    logic [BANK_W-1:0] en_q;
    logic [BANK_W-1:0] msk_q;

    // Hold enable and mask bits, loaded by full-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            msk_q <= '0;
        end else begin
            if (en_we_i)  en_q  <= wdata_i[BANK_W-1:0];
            if (msk_we_i) msk_q <= wdata_i[BANK_W-1:0];
        end
    end

    // Gate pending sources by enable and mask.
    always_comb act_o = pend_i & en_q & ~msk_q;

    assign en_o  = en_q;
    assign msk_o = msk_q;

    // R10: an enable write lands in the register at the next edge
    assert_en_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        en_we_i |=> (en_o == $past(wdata_i[BANK_W-1:0])));

    // R4: a masked bit never shows as active
    assert_mask_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((act_o & msk_o) == '0));

endmodule

// File: rtl/intc_nmi.sv
// Trigger detector and sticky pending latch for source 0.
// The latch is set by the selected level or edge and cleared by software.
// Assumes line_i is already synchronous to clk.
module intc_nmi
    import intc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  line_i,
    input  trig_e mode_i,
    input  logic  clr_i,
    output logic  pend_o
);

    logic prev_q;
    logic pend_q;
    logic trig;

    // Decide whether the current line state fires the trigger.
    always_comb begin
        unique case (mode_i)
            TRIG_HIGH: trig = line_i;
            TRIG_LOW:  trig = !line_i;
            TRIG_RISE: trig = line_i && !prev_q;
            TRIG_FALL: trig = !line_i && prev_q;
            default:   trig = 1'b0;
        endcase
    end

    // Track the previous line level and hold pending; set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= line_i;
            if (trig)       pend_q <= 1'b1;
            else if (clr_i) pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    // R7: pending stays set unless software clears it
    assert_nmi_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o);

    // R8: in rising mode a clear with the line low always takes effect
    assert_nmi_rise_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && mode_i == TRIG_RISE && !line_i) |=> !pend_o);

endmodule

// File: rtl/intc_lowest.sv
// Finds the lowest set bit of an N-bit vector and reports its index.
// Purely combinational; clk and rst_n only clock the checks.
module intc_lowest #(
    parameter int N = 96,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     vec_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the top so the lowest set index is the last one taken.
    always_comb begin
        any_o = |vec_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end

    // R11: the reported bit is set
    assert_pick_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> vec_i[idx_o]);

    // R11: no set bit lies below the reported one
    assert_pick_lowest_R11: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> ((vec_i & ((N'(1) << idx_o) - N'(1))) == '0));

    // R2: an empty vector reports index zero
    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !any_o |-> (idx_o == '0));

endmodule

// File: rtl/irq_vec_ctrl.sv
// Vectored interrupt controller: banks of enable and mask state,
// a sticky triggered source 0, a lowest-index vector and a registered
// interrupt output. Register reads are combinational; writes take
// effect at the clock edge. Assumes bus_addr_i is a byte offset.
module irq_vec_ctrl
    import intc_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 8,
    parameter bit ALT_MAP   = 1'b0,
    localparam int NSRC     = NUM_BANKS * BANK_W,
    localparam int IDX_W    = $clog2(NSRC),
    localparam int EN_BASE  = ALT_MAP ? EN_BASE_ALT : EN_BASE_STD,
    localparam int MSK_BASE = ALT_MAP ? MSK_BASE_ALT : MSK_BASE_STD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o
);

    logic              prot_q;
    trig_e             trig_q;
    logic              nmi_pend;
    logic              nmi_clr;
    logic [NSRC-1:0]   pend;
    logic [NSRC-1:0]   en_all;
    logic [NSRC-1:0]   msk_all;
    logic [NSRC-1:0]   act_all;
    logic              any_act;
    logic [IDX_W-1:0]  act_idx;
    logic              irq_q;

    // Software clears source 0 with a one in bit 0 of pending bank 0.
    always_comb nmi_clr = bus_we_i && (bus_addr_i == ADDR_W'(OFF_PENDING))
                          && bus_wdata_i[0];

    intc_nmi u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (src_i[0]),
        .mode_i (trig_q),
        .clr_i  (nmi_clr),
        .pend_o (nmi_pend)
    );

    // Level sources are pending while their line is high.
    always_comb pend = {src_i[NSRC-1:1], nmi_pend};

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic en_we;
        logic msk_we;
        always_comb en_we  = bus_we_i && (bus_addr_i == ADDR_W'(EN_BASE + 4 * b));
        always_comb msk_we = bus_we_i && (bus_addr_i == ADDR_W'(MSK_BASE + 4 * b));
        intc_bank #(.BANK_W(BANK_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_we_i  (en_we),
            .msk_we_i (msk_we),
            .wdata_i  (bus_wdata_i),
            .pend_i   (pend[b*BANK_W +: BANK_W]),
            .en_o     (en_all[b*BANK_W +: BANK_W]),
            .msk_o    (msk_all[b*BANK_W +: BANK_W]),
            .act_o    (act_all[b*BANK_W +: BANK_W])
        );
    end

    intc_lowest #(.N(NSRC)) u_lowest (
        .clk   (clk),
        .rst_n (rst_n),
        .vec_i (act_all),
        .any_o (any_act),
        .idx_o (act_idx)
    );

    // Control registers: protection bit and source-0 trigger type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= 1'b0;
            trig_q <= TRIG_HIGH;
        end else if (bus_we_i) begin
            if (bus_addr_i == ADDR_W'(OFF_PROTECT)) prot_q <= bus_wdata_i[0];
            if (bus_addr_i == ADDR_W'(OFF_TRIGCTL)) trig_q <= trig_e'(bus_wdata_i[1:0]);
        end
    end

    // Register the OR of all active sources toward the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= any_act;
    end

    assign irq_o = irq_q;

    // Read mux; unmapped offsets return zero.
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_W'(OFF_VECTOR) && any_act)
            bus_rdata_o = 32'(act_idx) << 2;
        if (bus_addr_i == ADDR_W'(OFF_PROTECT))
            bus_rdata_o = {31'b0, prot_q};
        if (bus_addr_i == ADDR_W'(OFF_TRIGCTL))
            bus_rdata_o = {30'b0, trig_q};
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr_i == ADDR_W'(OFF_PENDING + 4 * b))
                bus_rdata_o = 32'(pend[b*BANK_W +: BANK_W]);
            if (bus_addr_i == ADDR_W'(EN_BASE + 4 * b))
                bus_rdata_o = 32'(en_all[b*BANK_W +: BANK_W]);
            if (bus_addr_i == ADDR_W'(MSK_BASE + 4 * b))
                bus_rdata_o = 32'(msk_all[b*BANK_W +: BANK_W]);
        end
    end

    // R5: an active source raises the output one clock later
    assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        any_act |=> irq_o);

    // R5: with nothing active the output drops one clock later
    assert_irq_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !any_act |=> !irq_o);

endmodule

// File: tb/tb_irq_vec_ctrl.sv
// Directed bench for irq_vec_ctrl: one task per scenario.
module tb_irq_vec_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] src = '0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_alt;
    logic        irq, irq_alt;
    int          n_checks = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    irq_vec_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    irq_vec_ctrl #(.ALT_MAP(1'b1)) dut_alt (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata_alt), .irq_o(irq_alt)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); chk(v, 0, "R1 vector");
        rd(8'h08, v); chk(v, 0, "R1 protect");
        rd(8'h0C, v); chk(v, 0, "R1 trigctl");
        rd(8'h40, v); chk(v, 0, "R1 enable0");
        rd(8'h58, v); chk(v, 0, "R1 mask2");
        chk(32'(irq), 0, "R1 irq");
    endtask

    task automatic t_pending_gate();
        logic [31:0] v;
        @(negedge clk); src[37] = 1'b1;
        cyc(1);
        rd(8'h14, v); chk(v, 32'h20, "R6 live pending");
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, v); chk(v, 32'h20, "R6 write-one ignored");
        chk(32'(irq), 0, "R3 disabled irq");
        rd(8'h00, v); chk(v, 0, "R3 disabled vector");
        wr(8'h44, 32'h20);
        cyc(1);
        chk(32'(irq), 1, "R3 enabled irq");
        rd(8'h00, v); chk(v, 37 * 4, "R2 vector 37");
    endtask

    task automatic t_priority_mask();
        logic [31:0] v;
        @(negedge clk); src[70] = 1'b1;
        wr(8'h48, 32'h40);
        rd(8'h00, v); chk(v, 37 * 4, "R11 lowest wins");
        @(negedge clk); src[37] = 1'b0;
        rd(8'h00, v); chk(v, 70 * 4, "R11 next source");
        wr(8'h58, 32'h40);
        rd(8'h00, v); chk(v, 0, "R4 masked vector");
        cyc(1);
        chk(32'(irq), 0, "R4 masked irq");
        @(negedge clk); src[70] = 1'b0;
        wr(8'h58, 0); wr(8'h48, 0);
    endtask

    task automatic t_timing();
        @(negedge clk); src[37] = 1'b1;
        #1; chk(32'(irq), 0, "R5 no change before edge");
        @(negedge clk); chk(32'(irq), 1, "R5 rise after one edge");
        src[37] = 1'b0;
        #1; chk(32'(irq), 1, "R5 held before edge");
        @(negedge clk); chk(32'(irq), 0, "R5 fall after one edge");
        wr(8'h44, 0);
    endtask

    task automatic t_nmi_level();
        logic [31:0] v;
        wr(8'h40, 32'h1);
        @(negedge clk); src[0] = 1'b1;
        @(negedge clk); src[0] = 1'b0;
        rd(8'h10, v); chk(v, 1, "R7 latched");
        rd(8'h00, v); chk(v, 0, "R2 source 0 vector zero");
        cyc(3);
        rd(8'h10, v); chk(v, 1, "R7 sticky");
        chk(32'(irq), 1, "R7 irq held");
        wr(8'h10, 32'hFFFF_FFFE);
        rd(8'h10, v); chk(v, 1, "R7 zero write ignored");
        wr(8'h10, 32'h1);
        rd(8'h10, v); chk(v, 0, "R7 cleared");
        @(negedge clk); chk(32'(irq), 0, "R7 irq dropped");
        @(negedge clk); src[0] = 1'b1;
        wr(8'h10, 32'h1);
        rd(8'h10, v); chk(v, 1, "R7 set wins over clear");
        @(negedge clk); src[0] = 1'b0;
        wr(8'h10, 32'h1);
    endtask

    task automatic t_nmi_modes();
        logic [31:0] v;
        wr(8'h0C, 32'd2);
        cyc(2);
        rd(8'h10, v); chk(v, 0, "R8 rise idle");
        @(negedge clk); src[0] = 1'b1;
        @(negedge clk);
        rd(8'h10, v); chk(v, 1, "R8 rise latched");
        wr(8'h10, 32'h1);
        rd(8'h10, v); chk(v, 0, "R8 rise no relatch");
        wr(8'h0C, 32'd1);
        rd(8'h10, v); chk(v, 0, "R8 low mode while high");
        @(negedge clk); src[0] = 1'b0;
        @(negedge clk);
        rd(8'h10, v); chk(v, 1, "R8 low latched");
        wr(8'h10, 32'h1);
        rd(8'h10, v); chk(v, 1, "R8 low level relatches");
        wr(8'h0C, 32'd3);
        wr(8'h10, 32'h1);
        rd(8'h10, v); chk(v, 0, "R8 fall idle");
        @(negedge clk); src[0] = 1'b1;
        @(negedge clk);
        rd(8'h10, v); chk(v, 0, "R8 fall ignores rise");
        src[0] = 1'b0;
        @(negedge clk);
        rd(8'h10, v); chk(v, 1, "R8 fall latched");
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, v); chk(v, 3, "R8 field width");
        wr(8'h0C, 0);
        wr(8'h10, 32'h1);
        wr(8'h40, 0);
    endtask

    task automatic t_protect_map();
        logic [31:0] v;
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, v); chk(v, 1, "R9 protect bit");
        wr(8'h08, 0);
        rd(8'h08, v); chk(v, 0, "R9 protect clear");
        rd(8'h04, v); chk(v, 0, "R10 unmapped 0x04");
        rd(8'h1C, v); chk(v, 0, "R10 unmapped 0x1C");
        wr(8'h20, 32'h1234_5678);
        wr(8'h34, 32'hA5A5_0000);
        addr = 8'h20; #1;
        chk(rdata_alt, 32'h1234_5678, "R10 alt enable base");
        chk(rdata, 0, "R10 std ignores 0x20");
        addr = 8'h34; #1;
        chk(rdata_alt, 32'hA5A5_0000, "R10 alt mask base");
        addr = 8'h40; #1;
        chk(rdata_alt, 0, "R10 alt 0x40 unmapped");
        wr(8'h48, 32'hFFFF_FFFF);
        rd(8'h48, v); chk(v, 32'hFFFF_FFFF, "R10 std enable bank2");
        rd(8'h5C, v); chk(v, 0, "R10 unmapped 0x5C");
    endtask

    initial begin
        cyc(3);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_pending_gate();
        t_priority_mask();
        t_timing();
        t_nmi_level();
        t_nmi_modes();
        t_protect_map();
        cyc(2);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule